// File: doc/BRIEF.md
# Pseudo-SRAM Hidden-Refresh Memory Core

This block is a scaled-down pseudo-static memory: a 1K x 16 dynamic array behind a simple SRAM-style host port with active-low chip enable, write enable, output enable and two byte-lane enables. Each row of the array (one 16-word page) forgets its contents if it goes too long without being restored. An internal scheduler restores rows in rotation. Refresh steals only idle array cycles, so the host never issues refresh commands. The only time a refresh becomes visible is a single stall cycle on `ready`, which occurs when a refresh has already been pushed back to its limit.

A four-bit configuration word, written through a dedicated strobe, does three things. It enables fast same-page reads. It chooses what happens while `sleep_n` is held low: either a low-power mode that keeps refreshing only the lowest rows, or a deep power-down that stops refresh and drops every word. For the partial mode it also sets how many rows are kept. When the block leaves deep power-down, `busy` is raised for a fixed interval. During that interval reads complete at once with zero data and writes are dropped.

The host side is sampled on the clock. An access is taken on a rising edge at which `ready` is high. Read data returns on `rdata`, qualified by a one-cycle `rvalid` pulse.

Top module: `psr_core`

## Requirements
- R1: After reset `ready` is 1, `busy` is 0, `rvalid` is 0, and the configuration word is 4'b1000. Any word that has not been written since reset reads as 16'hDEAD.
- R2: A write with `ub_n` low stores bits 15:8 and a write with `lb_n` low stores bits 7:0. A lane that is not enabled keeps its old byte, or becomes 8'h00 if the word held no data. A read always returns the whole word.
- R3: With configuration bit 3 set, a read whose page (`addr[9:4]`) equals the page of the previous accepted read raises `rvalid` in the next cycle. Every other read raises `rvalid` three cycles after acceptance, and `ready` stays low in between.
- R4: One row is due for refresh every 8 clocks, and a host access wins the array over a refresh. A pending refresh is deferred for at most 4 cycles. In the following cycle `ready` drops for exactly one cycle and the refresh runs. Stored data survives both long idle periods and uninterrupted host traffic.
- R5: A `cfg_we` pulse loads `cfg_wdata`. Bit 0 picks the sleep mode (0 = partial refresh, 1 = deep power-down). Bits 2:1 pick the kept share of rows counted from address 0 (0 = all, 1 = half, 2 = quarter, 3 = eighth). Bit 3 enables same-page reads. The sleep settings are captured when sleep begins.
- R6: In the cycle after `sleep_n` is sampled low, `ready` is low and host accesses are ignored. Leaving partial-refresh sleep does not raise `busy`.
- R7: In partial-refresh sleep, words below address 1024 >> (bits 2:1) keep their data. A row that is neither accessed nor refreshed for 1024 cycles loses all its words, which then read 16'hDEAD.
- R8: Entering deep power-down invalidates every word. After waking, all words read 16'hDEAD, and a single-lane write leaves the other lane at 8'h00.
- R9: After deep power-down ends, `busy` is high for 16 cycles starting in the cycle after `sleep_n` is sampled high. In that window a read is accepted, raises `rvalid` in the next cycle with `rdata` = 0, and a write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low (wins over output enable) |
| oe_n | input | 1 | Output enable, active low (read request) |
| ub_n | input | 1 | Upper byte lane enable, active low |
| lb_n | input | 1 | Lower byte lane enable, active low |
| sleep_n | input | 1 | Low-power request, active low |
| addr | input | 10 | Word address |
| wdata | input | 16 | Write data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 4 | Configuration value |
| rdata | output | 16 | Read data |
| rvalid | output | 1 | Read data valid pulse |
| ready | output | 1 | Access will be accepted at the next rising edge |
| busy | output | 1 | Wake-up interval after deep power-down |

## Verification
The hardest case to reach from the ports is a refresh that reaches its deferral limit. That only happens when the host occupies the array on every cycle. The bench therefore holds a same-page read request asserted for 3000 consecutive cycles, so every accepted read is a one-cycle hit and no idle cycle is ever left for refresh. It then counts the stall cycles against one per refresh interval, confirms that no two stalls are adjacent, and sweeps the whole array to prove that nothing decayed. Row decay is reached by holding partial-refresh sleep far longer than the retention limit, and the bench computes which addresses must survive from the configured share.

// File: rtl/psr_pkg.sv
// psr_pkg: types shared by the pseudo-SRAM core.
// Assumes: configuration word is four bits, laid out as below.
package psr_pkg;

    // Configuration word: [3] page reads, [2:1] kept share, [0] deep sleep.
    typedef struct packed {
        logic       page_en;
        logic [1:0] keep_sel;
        logic       deep;
    } psr_cfg_t;

endpackage

// File: rtl/psr_refresh_sched.sv
// psr_refresh_sched: self-timed refresh request, deferral and row rotation.
// What it does: raises a pending refresh every REF_INT clocks and serves it
// in any cycle without a host access. After MAX_DEFER deferrals it forces the
// refresh and tells the top to stall the host. Rows rotate below keep_rows.
// Assumes: REF_INT >= 2; host_acc already excludes cycles with force_ref.
module psr_refresh_sched #(
    parameter int ROWS      = 64,
    parameter int REF_INT   = 8,
    parameter int MAX_DEFER = 4,
    localparam int RW       = $clog2(ROWS),
    localparam int TW       = $clog2(REF_INT),
    localparam int DW       = $clog2(MAX_DEFER + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          host_acc,
    input  logic [RW:0]   keep_rows,
    output logic          ref_do,
    output logic [RW-1:0] ref_row,
    output logic          force_ref,
    output logic          pending
);

    logic [TW-1:0] tick;
    logic [DW-1:0] defer;
    logic [RW-1:0] ptr;
    logic          tick_done;
    logic [RW:0]   row_inc;

    assign tick_done = (tick == TW'(REF_INT - 1));
    assign force_ref = pending && (defer == DW'(MAX_DEFER));
    assign ref_do    = pending && (force_ref || !host_acc);
    assign ref_row   = ({1'b0, ptr} >= keep_rows) ? '0 : ptr;
    assign row_inc   = {1'b0, ref_row} + {{RW{1'b0}}, 1'b1};

    // Interval timer that marks when the next row is due.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) tick <= '0;
        else                tick <= tick_done ? '0 : tick + 1'b1;
    end

    // Pending flag and count of cycles it has been deferred.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pending <= 1'b0;
            defer   <= '0;
        end else begin
            pending <= (pending && !ref_do) || tick_done;
            defer   <= (pending && !ref_do) ? defer + 1'b1 : '0;
        end
    end

    // Round-robin row pointer, wrapping inside the kept region.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= '0;
        else if (ref_do) ptr <= (row_inc >= keep_rows) ? '0 : row_inc[RW-1:0];
    end

endmodule

// File: rtl/psr_decay.sv
// psr_decay: per-row retention timers of the dynamic array.
// What it does: every row ages each cycle. A refresh or host access to the
// row restarts it, and a row reaching RETAIN cycles pulses its expire bit.
// Assumes: hold_all freezes all rows at zero (refresh-off power state).
module psr_decay #(
    parameter int ROWS   = 64,
    parameter int RETAIN = 1024,
    localparam int RW    = $clog2(ROWS),
    localparam int AGW   = $clog2(RETAIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold_all,
    input  logic            ref_do,
    input  logic [RW-1:0]   ref_row,
    input  logic            touch,
    input  logic [RW-1:0]   touch_row,
    output logic [ROWS-1:0] expire
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [AGW-1:0] age;
        logic           restore;

        assign restore   = (ref_do && ref_row == RW'(r)) || (touch && touch_row == RW'(r));
        assign expire[r] = !hold_all && !restore && (age == AGW'(RETAIN - 1));

        // Age of this row since it was last restored.
        always_ff @(posedge clk) begin
            if (!rst_n || hold_all || restore || expire[r]) age <= '0;
            else                                           age <= age + 1'b1;
        end
    end

endmodule

// File: rtl/psr_array.sv
// psr_array: word storage with per-word validity and byte-lane merge.
// What it does: a write merges enabled lanes over the old word (zero if the
// word holds nothing) and marks it valid. A killed row clears the valid bits
// of all its words. Reads of invalid words return POISON.
// Assumes: kill and write in the same cycle resolve in favour of the write.
module psr_array #(
    parameter int          ADDR_W = 10,
    parameter int          PAGE_W = 4,
    parameter int          DATA_W = 16,
    parameter logic [15:0] POISON = 16'hDEAD,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int WPR   = 1 << PAGE_W,
    localparam int ROWS  = 1 << (ADDR_W - PAGE_W),
    localparam int NB    = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NB-1:0]     lane_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ROWS-1:0]   kill,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  valid;
    logic [DATA_W-1:0] base;
    logic [DATA_W-1:0] merged;

    assign base    = valid[addr] ? mem[addr] : '0;
    assign rd_word = valid[addr] ? mem[addr] : DATA_W'(POISON);

    for (genvar l = 0; l < NB; l++) begin : g_lane
        assign merged[l*8 +: 8] = lane_en[l] ? wdata[l*8 +: 8] : base[l*8 +: 8];
    end

    // Word storage; contents are meaningless until marked valid.
    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= merged;
    end

    // Validity: cleared by row loss, set by any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
        end else begin
            for (int r = 0; r < ROWS; r++) begin
                if (kill[r]) valid[r*WPR +: WPR] <= '0;
            end
            if (wr_en) valid[addr] <= 1'b1;
        end
    end

endmodule

// File: rtl/psr_core.sv
// psr_core: pseudo-SRAM core with hidden refresh and sleep modes.
// What it does: takes SRAM-style accesses on rising edges while ready is
// high, hides row refresh in idle cycles, times reads by page hit or miss,
// and handles partial-refresh and deep power-down sleep.
// Assumes: host signals are synchronous to clk; DATA_W is two byte lanes.
module psr_core #(
    parameter int          ADDR_W     = 10,
    parameter int          PAGE_W     = 4,
    parameter int          REF_INT    = 8,
    parameter int          MAX_DEFER  = 4,
    parameter int          RETAIN_CYC = 1024,
    parameter int          MISS_LAT   = 3,
    parameter int          WAKE_CYC   = 16,
    parameter logic [3:0]  CFG_RST    = 4'b1000,
    parameter logic [15:0] POISON     = 16'hDEAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic              sleep_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_wdata,
    output logic [15:0]       rdata,
    output logic              rvalid,
    output logic              ready,
    output logic              busy
);
    import psr_pkg::*;

    localparam int DATA_W = 16;
    localparam int NB     = DATA_W / 8;
    localparam int RW     = ADDR_W - PAGE_W;
    localparam int ROWS   = 1 << RW;
    localparam int LW     = $clog2(MISS_LAT + 1);
    localparam int WKW    = $clog2(WAKE_CYC + 1);

    psr_cfg_t          cfg_q, mode_q;
    logic              slp_q, in_deep, deep_enter, run;
    logic [WKW-1:0]    wake_cnt;
    logic [LW-1:0]     wait_cnt;
    logic [RW-1:0]     last_page, page;
    logic              last_vld, hit;
    logic              req, acc, acc_wr, acc_rd;
    logic [RW:0]       keep_rows;
    logic              ref_do, force_ref, ref_pending;
    logic [RW-1:0]     ref_row;
    logic [ROWS-1:0]   expire, kill;
    logic [NB-1:0]     lane_en;
    logic [DATA_W-1:0] rd_word, rdata_q;

    assign page       = addr[ADDR_W-1:PAGE_W];
    assign in_deep    = slp_q && mode_q.deep;
    assign deep_enter = !sleep_n && !slp_q && cfg_q.deep;
    assign run        = !in_deep && !deep_enter;
    assign keep_rows  = (slp_q && !mode_q.deep) ? ((RW+1)'(ROWS) >> mode_q.keep_sel)
                                                 : (RW+1)'(ROWS);
    assign busy       = (wake_cnt != '0);
    assign ready      = !slp_q && (wait_cnt <= LW'(1)) && !force_ref;
    assign req        = !ce_n && (!we_n || !oe_n);
    assign acc        = req && ready;
    assign acc_wr     = acc && !we_n;
    assign acc_rd     = acc && we_n;
    assign hit        = cfg_q.page_en && last_vld && (page == last_page);
    assign lane_en    = {!ub_n, !lb_n};
    assign kill       = expire | {ROWS{deep_enter}};
    assign rvalid     = (wait_cnt == LW'(1));
    assign rdata      = rdata_q;

    // Configuration register, loaded by its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= psr_cfg_t'(CFG_RST);
        else if (cfg_we) cfg_q <= psr_cfg_t'(cfg_wdata);
    end

    // Sleep state and the configuration captured at sleep entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slp_q  <= 1'b0;
            mode_q <= psr_cfg_t'(CFG_RST);
        end else begin
            slp_q <= !sleep_n;
            if (!sleep_n && !slp_q) mode_q <= cfg_q;
        end
    end

    // Wake-up interval after deep power-down.
    always_ff @(posedge clk) begin
        if (!rst_n)                             wake_cnt <= '0;
        else if (in_deep && sleep_n)            wake_cnt <= WKW'(WAKE_CYC);
        else if (wake_cnt != '0)                wake_cnt <= wake_cnt - 1'b1;
    end

    // Read capture and latency countdown (hit, miss or wake-up zero).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
            rdata_q  <= '0;
        end else if (acc_rd) begin
            rdata_q  <= busy ? '0 : rd_word;
            wait_cnt <= (busy || hit) ? LW'(1) : LW'(MISS_LAT);
        end else if (wait_cnt != '0) begin
            wait_cnt <= wait_cnt - 1'b1;
        end
    end

    // Page of the last array read, forgotten on sleep entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_vld  <= 1'b0;
            last_page <= '0;
        end else if (!sleep_n && !slp_q) begin
            last_vld <= 1'b0;
        end else if (acc_rd && !busy) begin
            last_vld  <= 1'b1;
            last_page <= page;
        end
    end

    psr_refresh_sched #(
        .ROWS(ROWS), .REF_INT(REF_INT), .MAX_DEFER(MAX_DEFER)
    ) u_sched (
        .clk(clk), .rst_n(rst_n), .run(run), .host_acc(acc),
        .keep_rows(keep_rows), .ref_do(ref_do), .ref_row(ref_row),
        .force_ref(force_ref), .pending(ref_pending)
    );

    psr_decay #(
        .ROWS(ROWS), .RETAIN(RETAIN_CYC)
    ) u_decay (
        .clk(clk), .rst_n(rst_n), .hold_all(in_deep), .ref_do(ref_do),
        .ref_row(ref_row), .touch(acc && !busy), .touch_row(page),
        .expire(expire)
    );

    psr_array #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .POISON(POISON)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(acc_wr && !busy && (lane_en != '0)),
        .addr(addr), .lane_en(lane_en), .wdata(wdata), .kill(kill),
        .rd_word(rd_word)
    );

endmodule

// File: rtl/psr_core_chk.sv
// psr_core_chk: temporal checks on the pseudo-SRAM core, bound to psr_core.
// Assumes: observes top-level ports plus scheduler and read-decision signals.
module psr_core_chk #(
    parameter int MAX_DEFER = 4,
    localparam int CW = $clog2(MAX_DEFER + 2)
) (
    input logic        clk,
    input logic        rst_n,
    input logic        sleep_n,
    input logic        ready,
    input logic        busy,
    input logic        rvalid,
    input logic [15:0] rdata,
    input logic        acc_rd,
    input logic        hit,
    input logic        ref_pending,
    input logic        ref_do,
    input logic        force_ref
);

    logic [CW-1:0] waited;

    // Independent count of consecutive deferred refresh cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                     waited <= '0;
        else if (ref_pending && !ref_do) waited <= waited + 1'b1;
        else                            waited <= '0;
    end

    p_ref_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pending && !ref_do) |-> (waited < CW'(MAX_DEFER)));

    p_force_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        force_ref |-> !ready);

    p_hit_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && hit && !busy) |=> rvalid);

    p_miss_slow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && !hit && !busy) |=> (!rvalid && !ready));

    p_sleep_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_n |=> !ready);

    p_wake_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && busy) |=> (rvalid && rdata == 16'h0000));

endmodule

bind psr_core psr_core_chk #(.MAX_DEFER(MAX_DEFER)) u_chk (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .ready(ready), .busy(busy),
    .rvalid(rvalid), .rdata(rdata), .acc_rd(acc_rd), .hit(hit),
    .ref_pending(ref_pending), .ref_do(ref_do), .force_ref(force_ref)
);

// File: tb/psr_core_tb.sv
`timescale 1ns/1ps
module psr_core_tb;

    localparam int N = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
    logic        sleep_n = 1'b1, cfg_we = 1'b0;
    logic [9:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [3:0]  cfg_wdata = '0;
    logic [15:0] rdata;
    logic        rvalid, ready, busy;

    always #2.5 clk = ~clk;

    psr_core u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .ub_n(ub_n), .lb_n(lb_n), .sleep_n(sleep_n), .addr(addr), .wdata(wdata),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .rdata(rdata), .rvalid(rvalid),
        .ready(ready), .busy(busy)
    );

    int          n_vec = 0, n_bad = 0;
    logic [15:0] model [N];
    bit          mvalid [N];
    bit          b_page_on = 1'b1, b_lastv = 1'b0;
    int          b_lastpg = 0;

    function automatic logic [15:0] pat(int a);
        return 16'((a * 40503) ^ 16'h3C5A);
    endfunction

    function automatic logic [15:0] expw(int a);
        return mvalid[a] ? model[a] : 16'hDEAD;
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_ready();
        while (!ready) @(negedge clk);
    endtask

    task automatic cfg(logic [3:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
        b_page_on = v[3];
    endtask

    // Write; eff says whether the model should take it.
    task automatic wr(int a, logic [15:0] d, bit ub, bit lb, bit eff);
        logic [15:0] base;
        wait_ready();
        ce_n = 1'b0; we_n = 1'b0; ub_n = !ub; lb_n = !lb;
        addr = 10'(a); wdata = d;
        @(posedge clk); @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; ub_n = 1'b1; lb_n = 1'b1;
        if (eff && (ub || lb)) begin
            base = mvalid[a] ? model[a] : 16'h0000;
            if (ub) base[15:8] = d[15:8];
            if (lb) base[7:0]  = d[7:0];
            model[a] = base; mvalid[a] = 1'b1;
        end
    endtask

    // Read with explicit expectation; lat 0 skips the latency check.
    task automatic rd_exp(int a, logic [15:0] exp, int lat, string req);
        int got;
        wait_ready();
        ce_n = 1'b0; oe_n = 1'b0; addr = 10'(a);
        @(posedge clk); @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
        got = 1;
        while (!rvalid && got < 10) begin @(negedge clk); got++; end
        check(rvalid && rdata == exp, req, {16'h0, rdata}, {16'h0, exp});
        if (lat != 0) check(got == lat, req, got, lat);
    endtask

    // Read with latency and data taken from the bench model.
    task automatic rd_auto(int a, string req);
        int lat;
        lat = (b_page_on && b_lastv && (a >> 4) == b_lastpg) ? 1 : 3;
        rd_exp(a, expw(a), lat, req);
        b_lastv = 1'b1; b_lastpg = a >> 4;
    endtask

    task automatic sweep(string req);
        for (int a = 0; a < N; a++) rd_auto(a, req);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        finish_run();
    end

    initial begin
        int stalls, dbl, cnt;
        bit prev_low;
        for (int a = 0; a < N; a++) begin model[a] = '0; mvalid[a] = 1'b0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and unwritten words
        check(ready == 1'b1, "R1 ready", ready, 1);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(rvalid == 1'b0, "R1 rvalid", rvalid, 0);
        rd_auto(0, "R1 unwritten");
        rd_auto(700, "R1 unwritten");

        // R2/R3: full word sweep, sequential reads give page hits and misses
        for (int a = 0; a < N; a++) wr(a, pat(a), 1'b1, 1'b1, 1'b1);
        sweep("R3 R2 sweep");

        // R2: single-lane writes over valid words
        for (int a = 0; a < 128; a++) wr(a, ~pat(a + 7), a[0] == 0, a[0] == 1, 1'b1);
        for (int a = 0; a < 128; a++) rd_auto(a, "R2 lanes");

        // R5/R3: page reads disabled, then page alternation with them enabled
        cfg(4'b0000);
        for (int a = 32; a < 48; a++) rd_auto(a, "R5 R3 page off");
        cfg(4'b1000);
        for (int k = 0; k < 8; k++) rd_auto((k % 2) * 16 + k, "R3 alternate");

        // R4: long idle, everything retained
        repeat (3000) @(negedge clk);
        sweep("R4 idle retain");

        // R4: uninterrupted same-page reads; one stall per refresh interval
        rd_auto(3, "R4 prime");
        ce_n = 1'b0; oe_n = 1'b0; addr = 10'd3;
        stalls = 0; dbl = 0; prev_low = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (!ready) begin stalls++; if (prev_low) dbl++; end
            prev_low = !ready;
            if (rvalid && rdata != expw(3)) check(1'b0, "R4 busy data", rdata, expw(3));
        end
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        check(stalls >= 373 && stalls <= 377, "R4 stall count", stalls, 375);
        check(dbl == 0, "R4 single stall", dbl, 0);
        sweep("R4 traffic retain");

        // R6/R7: partial-refresh sleep keeping a quarter of the rows
        cfg(4'b1100);
        @(negedge clk); sleep_n = 1'b0; b_lastv = 1'b0;
        @(negedge clk);
        check(ready == 1'b0, "R6 ready low", ready, 0);
        ce_n = 1'b0; we_n = 1'b0; ub_n = 1'b0; lb_n = 1'b0; addr = 10'd5; wdata = 16'h1111;
        repeat (3) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; ub_n = 1'b1; lb_n = 1'b1;
        repeat (2500) @(negedge clk);
        sleep_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R6 no busy", busy, 0);
        for (int a = 256; a < N; a++) mvalid[a] = 1'b0;
        sweep("R7 R6 partial");

        // R8/R9: deep power-down, wake interval length
        for (int a = 0; a < N; a++) wr(a, pat(a + 3), 1'b1, 1'b1, 1'b1);
        cfg(4'b1001);
        @(negedge clk); sleep_n = 1'b0; b_lastv = 1'b0;
        repeat (40) @(negedge clk);
        sleep_n = 1'b1;
        @(negedge clk);
        cnt = 0;
        while (busy && cnt < 100) begin cnt++; @(negedge clk); end
        check(cnt == 16, "R9 busy length", cnt, 16);

        // R9: accesses inside the wake interval
        @(negedge clk); sleep_n = 1'b0;
        repeat (20) @(negedge clk);
        sleep_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R9 busy up", busy, 1);
        rd_exp(100, 16'h0000, 1, "R9 zero read");
        wr(7, 16'h7777, 1'b1, 1'b1, 1'b0);
        rd_exp(8, 16'h0000, 1, "R9 zero read");
        while (busy) @(negedge clk);
        for (int a = 0; a < N; a++) mvalid[a] = 1'b0;
        sweep("R8 R9 all lost");

        // R8/R2: single-lane writes into empty words
        wr(9, 16'hAB12, 1'b0, 1'b1, 1'b1);
        wr(10, 16'h34CD, 1'b1, 1'b0, 1'b1);
        rd_auto(9, "R8 R2 low lane");
        rd_auto(10, "R8 R2 high lane");
        check(model[9] == 16'h0012 && model[10] == 16'h3400, "R2 model", model[9], 16'h0012);

        finish_run();
    end

endmodule